// File: doc/BRIEF.md
# Windowed Input Time Accumulator

This block is one channel of a timer unit. It measures how long a filtered input signal stays at a chosen level (high or low) during a window of time. The window is set by two compare values held in registers and matched against a shared time base bus that counts elsewhere in the chip. A separate strobe marks each cycle in which the time base presents a new value. The input filter and the time base generator are outside the block.

When the time base reaches the start compare value, the channel clears its accumulator and arms. While armed, the accumulator adds one on every time base tick in which the input is at the selected level. When the time base reaches the end compare value, the channel disarms and raises a sticky flag. The accumulator then holds the measured time until the next window starts, and software reads it through a small register port.

Top module: `win_time_acc`

## Requirements
- R1: After reset, both compare registers, the accumulator, the polarity bit, the flag and the armed state are all zero.
- R2: On a cycle with `tb_tick` high and `tb_val` equal to the start compare value, the accumulator is cleared to zero and the channel is armed from the next cycle.
- R3: While armed, on each cycle with `tb_tick` high, the accumulator adds one when `sig_in` equals the polarity bit (1 measures high time, 0 measures low time) and holds its value otherwise.
- R4: On a cycle with `tb_tick` high and `tb_val` equal to the end compare value, the channel disarms and the flag is set. The accumulator keeps its value from then on.
- R5: When one tick matches the start and end values together, the end match wins: the accumulator is cleared, the channel stays disarmed and the flag is set.
- R6: The flag stays set until a write to the control register with bit 3 set. A set in the same cycle as the clear wins. A start match does not clear the flag.
- R7: Control bits 1 and 2, the force-start and force-end bits, have no effect: writing them neither arms, disarms, counts nor sets the flag, and they read back as zero.
- R8: The accumulator saturates at its all-ones value and does not wrap.
- R9: Register map, selected by a 2-bit address: 0 is the start compare, 1 is the end compare, 2 is the accumulator (read only; writes are ignored), 3 is control. Control reads return polarity in bit 0, flag in bit 3 and armed in bit 4. Writes set polarity from bit 0. All values are zero-extended to 32 bits.
- R10: Compare matches and counting happen only on cycles with `tb_tick` high. On other cycles the accumulator and the armed state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_tick | input | 1 | Time base advance strobe |
| tb_val | input | TB_W (24) | Shared time base value |
| sig_in | input | 1 | Filtered input level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| flag_o | output | 1 | Sticky end-of-window flag |
| armed_o | output | 1 | Window open, accumulator counting enabled |

## Verification
Random windows at random places in the 24-bit range run with a random input level and random gaps between ticks, and with both polarities, so that counting by level, hold on the wrong level and hold between ticks can be told apart. Directed patterns cover the following: a time base that equals a compare value while no tick is present, equal start and end values, a flag clear in the same cycle as an end match, and a new window started while the flag is still set. Force bits are written both while idle and while armed, and a write to the read-only accumulator address is tried. A narrow second instance runs a long window so that saturation can be seen, which shows it apart from wrapping.

// File: rtl/wta_pkg.sv
package wta_pkg;

    typedef enum logic [1:0] {
        REG_CMP_A = 2'd0,
        REG_CMP_B = 2'd1,
        REG_ACC   = 2'd2,
        REG_CTRL  = 2'd3
    } wta_reg_e;

    localparam int CTL_POL   = 0;
    localparam int CTL_FRC_A = 1;
    localparam int CTL_FRC_B = 2;
    localparam int CTL_FLAG  = 3;
    localparam int CTL_ARMED = 4;

endpackage

// File: rtl/wta_regs.sv
module wta_regs
    import wta_pkg::*;
#(
    parameter int TB_W   = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              b_hit,
    output logic [TB_W-1:0]   cmp_a,
    output logic [TB_W-1:0]   cmp_b,
    output logic              pol,
    output logic              flag
);

    typedef struct packed {
        logic [TB_W-1:0] cmp_a;
        logic [TB_W-1:0] cmp_b;
        logic            pol;
        logic            flag;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            unique case (wta_reg_e'(wr_addr))
                REG_CMP_A: s_d.cmp_a = wr_data[TB_W-1:0];
                REG_CMP_B: s_d.cmp_b = wr_data[TB_W-1:0];
                REG_CTRL: begin
                    s_d.pol = wr_data[CTL_POL];
                    if (wr_data[CTL_FLAG]) begin
                        s_d.flag = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (b_hit) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_a = s_q.cmp_a;
    assign cmp_b = s_q.cmp_b;
    assign pol   = s_q.pol;
    assign flag  = s_q.flag;

endmodule

// File: rtl/wta_match.sv
module wta_match #(
    parameter int TB_W  = 24,
    parameter int N_CMP = 2
) (
    input  logic                       tb_tick,
    input  logic [TB_W-1:0]            tb_val,
    input  logic [N_CMP-1:0][TB_W-1:0] cmp_val,
    output logic [N_CMP-1:0]           hit
);

    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        always_comb begin
            hit[gi] = tb_tick && (tb_val == cmp_val[gi]);
        end
    end

endmodule

// File: rtl/wta_accum.sv
module wta_accum #(
    parameter int TB_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tb_tick,
    input  logic            sig_in,
    input  logic            pol,
    input  logic            a_hit,
    input  logic            b_hit,
    output logic [TB_W-1:0] acc,
    output logic            armed
);

    localparam logic [TB_W-1:0] ACC_MAX = {TB_W{1'b1}};

    typedef struct packed {
        logic            armed;
        logic [TB_W-1:0] acc;
    } acc_t;

    acc_t s_d, s_q;
    logic level_ok;

    always_comb begin
        level_ok = (sig_in == pol);
        s_d      = s_q;
        if (b_hit) begin
            s_d.armed = 1'b0;
            if (a_hit) begin
                s_d.acc = '0;
            end
        end else if (a_hit) begin
            s_d.armed = 1'b1;
            s_d.acc   = '0;
        end else if (tb_tick && s_q.armed && level_ok && (s_q.acc != ACC_MAX)) begin
            s_d.acc = s_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc   = s_q.acc;
    assign armed = s_q.armed;

endmodule

// File: rtl/win_time_acc.sv
module win_time_acc
    import wta_pkg::*;
#(
    parameter int TB_W   = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_tick,
    input  logic [TB_W-1:0]   tb_val,
    input  logic              sig_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag_o,
    output logic              armed_o
);

    localparam int N_CMP = 2;

    logic [TB_W-1:0]            cmp_a;
    logic [TB_W-1:0]            cmp_b;
    logic                       pol;
    logic                       flag;
    logic [N_CMP-1:0][TB_W-1:0] cmp_vec;
    logic [N_CMP-1:0]           hit_vec;
    logic                       a_hit;
    logic                       b_hit;
    logic [TB_W-1:0]            acc_val;
    logic                       armed;

    wta_regs #(.TB_W(TB_W), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .b_hit   (b_hit),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .pol     (pol),
        .flag    (flag)
    );

    assign cmp_vec[0] = cmp_a;
    assign cmp_vec[1] = cmp_b;

    wta_match #(.TB_W(TB_W), .N_CMP(N_CMP)) match_i (
        .tb_tick (tb_tick),
        .tb_val  (tb_val),
        .cmp_val (cmp_vec),
        .hit     (hit_vec)
    );

    assign a_hit = hit_vec[0];
    assign b_hit = hit_vec[1];

    wta_accum #(.TB_W(TB_W)) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tb_tick (tb_tick),
        .sig_in  (sig_in),
        .pol     (pol),
        .a_hit   (a_hit),
        .b_hit   (b_hit),
        .acc     (acc_val),
        .armed   (armed)
    );

    always_comb begin
        rd_data = '0;
        unique case (wta_reg_e'(rd_addr))
            REG_CMP_A: rd_data[TB_W-1:0] = cmp_a;
            REG_CMP_B: rd_data[TB_W-1:0] = cmp_b;
            REG_ACC:   rd_data[TB_W-1:0] = acc_val;
            REG_CTRL: begin
                rd_data[CTL_POL]   = pol;
                rd_data[CTL_FLAG]  = flag;
                rd_data[CTL_ARMED] = armed;
            end
            default: ;
        endcase
    end

    assign flag_o  = flag;
    assign armed_o = armed;

endmodule

// File: rtl/wta_chk.sv
module wta_chk
    import wta_pkg::*;
#(
    parameter int TB_W   = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tb_tick,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              a_hit,
    input logic              b_hit,
    input logic [TB_W-1:0]   acc,
    input logic              armed,
    input logic              flag
);

    logic flag_clr;
    assign flag_clr = wr_en && (wr_addr == REG_CTRL) && wr_data[CTL_FLAG];

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !b_hit) |=> (armed && (acc == '0)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !a_hit && !b_hit) |=> ((acc == $past(acc)) || (acc == $past(acc) + 1'b1)));

    p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_hit |=> (!armed && flag));

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !a_hit) |=> $stable(acc));

    p_end_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && b_hit) |=> (!armed && (acc == '0)));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (acc == {TB_W{1'b1}}) && !a_hit) |=> (acc == {TB_W{1'b1}}));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_tick |=> ($stable(acc) && $stable(armed)));

endmodule

bind win_time_acc wta_chk #(.TB_W(TB_W), .DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tb_tick (tb_tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .a_hit   (a_hit),
    .b_hit   (b_hit),
    .acc     (acc_val),
    .armed   (armed),
    .flag    (flag)
);

// File: tb/win_time_acc_tb_top.sv
module win_time_acc_tb_top;

    localparam int TB_W = 24;
    localparam int SW   = 4;
    localparam logic [TB_W-1:0] MAXV = {TB_W{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic [TB_W-1:0] tb_val = '0;
    logic        sig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        flag_o, armed_o;

    logic        s_tick = 1'b0;
    logic [SW-1:0] s_val = '0;
    logic        s_sig = 1'b0;
    logic        s_we = 1'b0;
    logic [1:0]  s_waddr = '0;
    logic [31:0] s_wdata = '0;
    logic [1:0]  s_raddr = 2'd2;
    logic [31:0] s_rdata;
    logic        s_flag, s_armed;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [TB_W-1:0] m_a, m_b, m_acc;
    logic m_pol, m_flag, m_arm;

    always #5 clk = ~clk;

    win_time_acc #(.TB_W(TB_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tb_val(tb_val), .sig_in(sig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .flag_o(flag_o), .armed_o(armed_o)
    );

    win_time_acc #(.TB_W(SW)) sat_i (
        .clk(clk), .rst_n(rst_n), .tb_tick(s_tick), .tb_val(s_val), .sig_in(s_sig),
        .wr_en(s_we), .wr_addr(s_waddr), .wr_data(s_wdata), .rd_addr(s_raddr),
        .rd_data(s_rdata), .flag_o(s_flag), .armed_o(s_armed)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: exp_read = {8'd0, m_a};
            2'd1: exp_read = {8'd0, m_b};
            2'd2: exp_read = {8'd0, m_acc};
            default: exp_read = {27'd0, m_arm, m_flag, 2'b00, m_pol};
        endcase
    endfunction

    task automatic model_step(input logic t, input logic [TB_W-1:0] v, input logic s,
                              input logic we, input logic [1:0] wa, input logic [31:0] wd);
        logic ha, hb;
        ha = t && (v == m_a);
        hb = t && (v == m_b);
        if (hb) begin
            m_arm = 1'b0;
            if (ha) m_acc = '0;
        end else if (ha) begin
            m_arm = 1'b1;
            m_acc = '0;
        end else if (t && m_arm && (s == m_pol) && (m_acc != MAXV)) begin
            m_acc = m_acc + 1'b1;
        end
        if (we) begin
            case (wa)
                2'd0: m_a = wd[TB_W-1:0];
                2'd1: m_b = wd[TB_W-1:0];
                2'd3: begin
                    m_pol = wd[0];
                    if (wd[3]) m_flag = 1'b0;
                end
                default: ;
            endcase
        end
        if (hb) m_flag = 1'b1;
    endtask

    task automatic drive(input logic t, input logic [TB_W-1:0] v, input logic s,
                         input logic we, input logic [1:0] wa, input logic [31:0] wd);
        @(negedge clk);
        tb_tick = t; tb_val = v; sig_in = s;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        model_step(t, v, s, we, wa, wd);
    endtask

    task automatic tick(input logic [TB_W-1:0] v, input logic s);
        drive(1'b1, v, s, 1'b0, 2'd0, 32'd0);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        drive(1'b0, tb_val, sig_in, 1'b1, a, d);
    endtask

    task automatic check_vec(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [1:0] a);
        @(negedge clk);
        tb_tick = 1'b0; wr_en = 1'b0;
        rd_addr = a;
        #1;
        check_vec(req, $sformatf("read addr %0d", a), rd_data, exp_read(a));
    endtask

    task automatic check_state(input string req);
        check_reg(req, 2'd2);
        check_reg(req, 2'd3);
        check_vec(req, "flag_o", {31'd0, flag_o}, {31'd0, m_flag});
        check_vec(req, "armed_o", {31'd0, armed_o}, {31'd0, m_arm});
    endtask

    task automatic run_window(input logic [TB_W-1:0] a, input int len, input logic p);
        logic [TB_W-1:0] cur;
        wreg(2'd0, {8'd0, a});
        wreg(2'd1, {8'd0, a + TB_W'(len)});
        wreg(2'd3, {28'd0, ($urandom % 2 == 0), 2'b00, p});
        cur = a - 3;
        while (cur != a + TB_W'(len + 3)) begin
            logic t;
            t = ($urandom % 4) != 0;
            drive(t, cur, 1'($urandom % 2), 1'b0, 2'd0, 32'd0);
            if (t) cur = cur + 1'b1;
            if (cur == a + TB_W'(len / 2) && t) check_state("R3");
        end
        check_state("R4");
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_a = '0; m_b = '0; m_acc = '0; m_pol = 1'b0; m_flag = 1'b0; m_arm = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 4; i++) check_reg("R1", 2'(i));
        check_state("R1");

        // R9: register map and read-only accumulator
        wreg(2'd0, 32'hAB00_0100);
        wreg(2'd1, 32'h0000_1500);
        wreg(2'd3, 32'h0000_0001);
        wreg(2'd2, 32'h00FF_FFFF);
        for (int i = 0; i < 4; i++) check_reg("R9", 2'(i));

        // R10: time base equal to start value but no tick
        drive(1'b0, 24'h000100, 1'b1, 1'b0, 2'd0, 32'd0);
        check_state("R10");

        // R2, R3: directed high-time window
        tick(24'h000100, 1'b1);
        check_state("R2");
        for (int i = 0; i < 10; i++) begin
            tick(24'h000101 + 24'(i), (i % 3) != 0);
            drive(1'b0, 24'h000101 + 24'(i), 1'b1, 1'b0, 2'd0, 32'd0);
        end
        check_state("R3");

        // R7: force bits while armed
        wreg(2'd3, 32'h0000_0007);
        check_state("R7");
        tick(24'h000200, 1'b1);
        check_state("R7");

        // R4: end match
        tick(24'h001500, 1'b1);
        check_state("R4");
        tick(24'h001501, 1'b1);
        check_state("R4");

        // R6: start match keeps flag, same-cycle clear loses to end match
        tick(24'h000100, 1'b1);
        check_state("R6");
        drive(1'b1, 24'h001500, 1'b1, 1'b1, 2'd3, 32'h0000_0009);
        check_state("R6");
        wreg(2'd3, 32'h0000_0009);
        check_state("R6");

        // R7: force bits while idle
        wreg(2'd3, 32'h0000_0006);
        tick(24'h000050, 1'b0);
        check_state("R7");

        // R5: equal start and end
        wreg(2'd1, 32'h0000_0100);
        tick(24'h000100, 1'b1);
        check_state("R5");

        // R3: low-time window
        wreg(2'd3, 32'h0000_0008);
        wreg(2'd1, 32'h0000_0120);
        tick(24'h000100, 1'b0);
        for (int i = 0; i < 8; i++) tick(24'h000101 + 24'(i), i < 5);
        check_state("R3");

        // R2, R3, R4, R6: random windows
        for (int w = 0; w < 40; w++) begin
            run_window(24'($urandom_range(8, 24'hFFFF00)), int'($urandom_range(4, 60)),
                       1'($urandom % 2));
        end
        run_window(24'hFFFFC0, 50, 1'b1);

        // R8: saturation on a narrow instance
        @(negedge clk);
        s_we = 1'b1; s_waddr = 2'd0; s_wdata = 32'd1;
        @(negedge clk);
        s_waddr = 2'd1; s_wdata = 32'd0;
        @(negedge clk);
        s_waddr = 2'd3; s_wdata = 32'd1;
        @(negedge clk);
        s_we = 1'b0; s_tick = 1'b1; s_val = 4'd1; s_sig = 1'b1;
        @(negedge clk);
        s_val = 4'd2;
        repeat (25) @(negedge clk);
        s_tick = 1'b0;
        s_raddr = 2'd2;
        #1;
        check_vec("R8", "saturated accumulator", s_rdata, 32'd15);
        check_vec("R8", "still armed", {31'd0, s_armed}, 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule